// File: doc/BRIEF.md
# Four-Phase Return-to-Zero Pipeline Stage Controller and FIFO

This block sequences one stage of a return-to-zero (four-phase) handshake pipeline and chains N such stages into a first-in first-out buffer. Each stage has a storage word held in a level-sensitive latch and a small controller. The controller faces its upstream neighbour through a request input and an acknowledge output, and faces its downstream neighbour through a request output and an acknowledge input. The design is a synchronous model: every handshake level is sampled on the clock, and every output is decoded from a registered state.

Each stage runs a fixed burst sequence. When the upstream request rises, the stage opens its latch and raises its acknowledge. When the request falls, the stage closes the latch. It raises its downstream request only after the downstream acknowledge of the previous transfer has returned low. When the downstream acknowledge rises, the stage drops its downstream request and its upstream acknowledge together. The upstream request is always back at zero before the downstream request is raised. As a result, the latch-open windows of neighbouring stages never overlap. With consumer back-pressure, every stage can hold a word.

A producer drives `in_req_i` and `in_data_i` and waits on `in_ack_o`. A consumer watches `out_req_o` and `out_data_o` and answers on `out_ack_i`.

Top module: `rtz_pipe_fifo`

## Requirements
- R1: When a stage is idle and samples its upstream request high, its acknowledge output and its latch enable are both high on the next cycle.
- R2: When a capturing stage samples its upstream request low, its latch enable is low on the next cycle. The downstream request rises in that same cycle if the downstream acknowledge was sampled low. Otherwise it waits until the downstream acknowledge is sampled low.
- R3: When a stage with its downstream request high samples the downstream acknowledge high, both its downstream request and its upstream acknowledge are low on the next cycle.
- R4: Once raised, a downstream request stays high, and the stage's output word stays unchanged, until the downstream acknowledge is sampled high.
- R5: The latch enables of two adjacent stages are never high in the same cycle.
- R6: A stage's upstream acknowledge stays high from capture until its downstream acknowledge rises, even after the upstream request has fallen. The upstream request may rise only while the acknowledge is low.
- R7: Words leave at the output in the order they entered, with none lost or duplicated, under arbitrary producer and consumer delays.
- R8: During reset all requests, acknowledges and latch enables are low and the stored words are zero.
- R9: A stage stores the input word present at the clock edge where its request is first sampled low. The producer may change the data from the following cycle.
- R10: With the consumer stalled, the FIFO accepts exactly N words (one per stage). The input acknowledge then stays high, and all latch enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_req_i | input | 1 | Producer request (four-phase) |
| in_ack_o | output | 1 | Acknowledge to producer |
| in_data_i | input | W | Producer data word |
| out_req_o | output | 1 | Request to consumer |
| out_ack_i | input | 1 | Consumer acknowledge |
| out_data_o | output | W | Data word to consumer |
| latch_en_o | output | N | Latch enable of each stage, bit i for stage i |

## Verification
The bench steps one word through the first two stages cycle by cycle. It checks that the first latch closes one cycle after the request falls and that the second latch opens only after that, so that overlapping enables would show up as both bits high. The producer changes its data one cycle after dropping its request. A stage that captured too late would therefore emit this garbage value instead of the word. With the consumer stalled, the bench checks that exactly N words are taken. A stage that raised its request before the previous acknowledge returned low would overwrite or drop a word, which the in-order scoreboard would report. Random producer and consumer delays then exercise the remaining interleavings against the same scoreboard.

// File: rtl/rtz_pipe_pkg.sv
package rtz_pipe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAPT = 2'd1,
    ST_HOLD = 2'd2,
    ST_SEND = 2'd3
  } stage_st_e;
endpackage

// File: rtl/rtz_stage_latch.sv
module rtz_stage_latch #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         le_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // transparent while le_i, modelled on the sampling clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (le_i) q_o <= d_i;
  end
endmodule

// File: rtl/rtz_stage_ctrl.sv
module rtz_stage_ctrl
  import rtz_pipe_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_in_i,
  output logic ack_in_o,
  output logic req_out_o,
  input  logic ack_out_i,
  output logic latch_en_o
);
  stage_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_in_i)  st_d = ST_CAPT;
      ST_CAPT: if (!req_in_i) st_d = ack_out_i ? ST_HOLD : ST_SEND;
      ST_HOLD: if (!ack_out_i) st_d = ST_SEND;
      ST_SEND: if (ack_out_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  // outputs decode the burst position directly
  assign ack_in_o   = (st_q != ST_IDLE);
  assign req_out_o  = (st_q == ST_SEND);
  assign latch_en_o = (st_q == ST_CAPT);

  p_capture_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_in_o && req_in_i) |=> (ack_in_o && latch_en_o));

  p_close_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_en_o && !req_in_i) |=> !latch_en_o);

  p_send_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_out_o) |-> $past(!req_in_i && !ack_out_i));

  p_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_out_o && ack_out_i) |=> (!req_out_o && !ack_in_o));

  p_req_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_out_o && !ack_out_i) |=> req_out_o);

  p_ack_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_in_o && !(req_out_o && ack_out_i)) |=> ack_in_o);

  p_env_rin_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_in_i) |-> !ack_in_o);
endmodule

// File: rtl/rtz_pipe_fifo.sv
module rtz_pipe_fifo #(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_req_i,
  output logic         in_ack_o,
  input  logic [W-1:0] in_data_i,
  output logic         out_req_o,
  input  logic         out_ack_i,
  output logic [W-1:0] out_data_o,
  output logic [N-1:0] latch_en_o
);
  localparam int LAST = N - 1;

  logic [N-1:0]        rin, ain, rout, aout, le;
  logic [N-1:0][W-1:0] q;

  for (genvar i = 0; i < N; i++) begin : g_stage
    logic [W-1:0] d;
    if (i == 0) begin : g_head
      assign rin[i] = in_req_i;
      assign d      = in_data_i;
    end else begin : g_body
      assign rin[i] = rout[i-1];
      assign d      = q[i-1];
    end
    if (i == LAST) begin : g_tail
      assign aout[i] = out_ack_i;
    end else begin : g_link
      assign aout[i] = ain[i+1];
      p_no_overlap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(le[i] && le[i+1]));
    end

    rtz_stage_ctrl u_ctrl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_in_i  (rin[i]),
      .ack_in_o  (ain[i]),
      .req_out_o (rout[i]),
      .ack_out_i (aout[i]),
      .latch_en_o(le[i])
    );

    rtz_stage_latch #(.W(W)) u_latch (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .le_i  (le[i]),
      .d_i   (d),
      .q_o   (q[i])
    );
  end

  assign in_ack_o   = ain[0];
  assign out_req_o  = rout[LAST];
  assign out_data_o = q[LAST];
  assign latch_en_o = le;

  p_out_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_req_o && !out_ack_i) |=> $stable(out_data_o));
endmodule

// File: tb/tb_rtz_pipe_fifo.sv
module tb_rtz_pipe_fifo;
  localparam int N = 4;
  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_req_i = 1'b0;
  logic         in_ack_o;
  logic [W-1:0] in_data_i = '0;
  logic         out_req_o;
  logic         out_ack_i = 1'b0;
  logic [W-1:0] out_data_o;
  logic [N-1:0] latch_en_o;

  int n_chk = 0;
  int n_fail = 0;
  int acc_cnt = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;
  logic [W-1:0] exp_q[$];

  always #5 clk_i = ~clk_i;

  rtz_pipe_fifo #(.N(N), .W(W)) dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [W-1:0] v);
    while (in_ack_o) @(negedge clk_i);
    exp_q.push_back(v);
    in_data_i = v;
    in_req_i  = 1'b1;
    while (!in_ack_o) @(negedge clk_i);
    acc_cnt++;
    repeat ($urandom_range(0, 3)) @(negedge clk_i);
    in_req_i = 1'b0;
    @(negedge clk_i);
    in_data_i = W'($urandom);  // garbage after hold cycle (R9)
    while (in_ack_o) @(negedge clk_i);
  endtask

  // scoreboard monitor / consumer
  initial begin
    forever begin
      @(negedge clk_i);
      if (mon_en && out_req_o) begin
        logic [W-1:0] e;
        repeat ($urandom_range(0, 3)) @(negedge clk_i);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected word", int'(out_data_o), 0);
        end else begin
          e = exp_q.pop_front();
          chk(out_data_o == e, "R7 order", int'(out_data_o), int'(e));
        end
        out_ack_i = 1'b1;
        while (out_req_o) @(negedge clk_i);
        repeat ($urandom_range(0, 3)) @(negedge clk_i);
        out_ack_i = 1'b0;
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      chk(1'b0, "watchdog", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R8 reset state
    chk(!in_ack_o && !out_req_o, "R8 handshake", {in_ack_o, out_req_o}, 0);
    chk(latch_en_o == '0, "R8 latch", int'(latch_en_o), 0);
    chk(out_data_o == '0, "R8 data", int'(out_data_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // directed single word
    in_data_i = 8'hA5;
    in_req_i  = 1'b1;
    @(negedge clk_i);
    chk(in_ack_o && latch_en_o[0], "R1 open+ack", {in_ack_o, latch_en_o[0]}, 3);
    in_req_i = 1'b0;
    @(negedge clk_i);
    chk(!latch_en_o[0], "R2 close", int'(latch_en_o[0]), 0);
    chk(in_ack_o, "R6 ack held after req low", int'(in_ack_o), 1);
    in_data_i = 8'h3C;
    @(negedge clk_i);
    chk(latch_en_o[1:0] == 2'b10, "R5 enables", int'(latch_en_o[1:0]), 2);
    chk(in_ack_o, "R6 ack held", int'(in_ack_o), 1);
    @(negedge clk_i);
    chk(!in_ack_o, "R3 ack released", int'(in_ack_o), 0);
    begin
      int t = 0;
      while (!out_req_o && t < 100) begin
        @(negedge clk_i);
        t++;
      end
    end
    chk(out_req_o, "R7 word arrives", int'(out_req_o), 1);
    chk(out_data_o == 8'hA5, "R9 captured word", int'(out_data_o), 'hA5);
    repeat (3) @(negedge clk_i);
    chk(out_req_o && out_data_o == 8'hA5, "R4 held", int'(out_data_o), 'hA5);
    out_ack_i = 1'b1;
    @(negedge clk_i);
    chk(!out_req_o, "R3 out req dropped", int'(out_req_o), 0);
    out_ack_i = 1'b0;
    repeat (4) @(negedge clk_i);

    // fill with consumer stalled
    acc_cnt = 0;
    fork
      begin
        for (int k = 0; k < N; k++) push(W'(8'h10 + k));
      end
      begin
        repeat (40 * N) @(negedge clk_i);
        chk(acc_cnt == N, "R10 accepted", acc_cnt, N);
        chk(in_ack_o, "R10 input held", int'(in_ack_o), 1);
        chk(latch_en_o == '0, "R10 latches closed", int'(latch_en_o), 0);
        chk(out_req_o && out_data_o == 8'h10, "R10 head word", int'(out_data_o), 'h10);
        mon_en = 1'b1;
      end
    join
    while (exp_q.size() != 0) @(negedge clk_i);

    // random traffic
    for (int k = 0; k < 150; k++) begin
      repeat ($urandom_range(0, 4)) @(negedge clk_i);
      push(W'($urandom));
    end
    while (exp_q.size() != 0) @(negedge clk_i);
    repeat (10) @(negedge clk_i);
    chk(!out_req_o && !in_ack_o, "R7 drained", {out_req_o, in_ack_o}, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule